// File: doc/BRIEF.md
# PHY Loopback Path Router

This block sits between the transmit and receive chains of a dual-speed (100 Mb/s and 10 Mb/s) Ethernet PHY. It decides what feeds each chain's inputs. The options are normal operation, local loopback and remote loopback. The encoders, decoders and clock recovery are outside the block; each one appears only as a tap signal that is `W` bits wide.

Normal operation sends transmit data to the line drivers and received line data to the receive chain.

Local loopback cuts the block off from the media:
- At 100 Mb/s, the NRZI encoder output goes into the receive-side NRZI decoder.
- At 10 Mb/s, the Manchester encoder output goes into the receive clock-recovery loop.

Remote loopback works only at 100 Mb/s. It takes the recovered receive stream and feeds it into the MLT-3 converter input, so line data is sent back onto the line.

The control bits and the speed mode are registered. The datapath muxes are driven only from these flops, so a mode change switches every path at one clock edge. The tap data itself goes through the muxes with no register stage.

Top module: `lbk_router`

## Requirements
- R1: While `rstN` is low, the block is in normal mode, whatever the control inputs are: `mediaIsolate` is 0 and every output carries its normal-mode source.
- R2: In normal mode (neither loopback bit set):
  - `rxNrziDecIn` equals `rxRecovTap`.
  - `txMlt3In` equals `txNrziTap`.
  - `rxPllIn10` equals `lineRx10`.
  - `tx10DrvIn` equals `txManchTap`.
  - `mediaIsolate` is 0.
- R3: In local loopback at either speed, `mediaIsolate` is 1, and `txMlt3In` and `tx10DrvIn` are both all zeros.
- R4: In local loopback at 100 Mb/s (`speed100`=1), `rxNrziDecIn` equals `txNrziTap`, and `rxPllIn10` still carries `lineRx10`.
- R5: In local loopback at 10 Mb/s (`speed100`=0), `rxPllIn10` equals `txManchTap`, and `rxNrziDecIn` still carries `rxRecovTap`.
- R6: In remote loopback at 100 Mb/s, `txMlt3In` equals `rxRecovTap` and `mediaIsolate` is 0. The receive outputs keep their normal sources, and `tx10DrvIn` carries `txManchTap`.
- R7: When `remoteLbEn`=1 and `speed100`=0, remote loopback has no effect, and every output matches normal mode.
- R8: When both loopback bits are 1, local loopback wins.
- R9: A change on `localLbEn`, `remoteLbEn` or `speed100` changes the routing at the first rising clock edge after the change, and not before. A change on tap data reaches the outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| localLbEn | input | 1 | Local loopback request |
| remoteLbEn | input | 1 | Remote loopback request (100 Mb/s only) |
| speed100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| txNrziTap | input | W | Output of the transmit NRZI encoder |
| txManchTap | input | W | Output of the Manchester encoder |
| rxRecovTap | input | W | Output of the 100 Mb/s data and clock recovery |
| lineRx10 | input | W | 10 Mb/s line receive data |
| rxNrziDecIn | output | W | Input of the receive NRZI decoder |
| rxPllIn10 | output | W | Input of the 10 Mb/s clock-recovery loop |
| txMlt3In | output | W | Input of the MLT-3 converter and 100 Mb/s line driver |
| tx10DrvIn | output | W | Input of the 10 Mb/s line driver |
| mediaIsolate | output | 1 | Line pins cut off from the media |

## Verification
Control changes have a latency of one clock edge, and tap data has a latency of zero. The bench drives every new input set at a falling edge.

Once the inputs settle, and before the next rising edge, the bench checks that the routing still matches the previous mode while the outputs already carry the new data. After the rising edge it checks the new routing. It then changes only the data and checks that the outputs follow it with no further edge.

The sweep covers every ordered pair of the eight control combinations.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_LOCAL  = 2'd1,
    MODE_REMOTE = 2'd2
  } lbMode_e;

  typedef struct packed {
    logic loc100;
    logic loc10;
    logic rem100;
    logic isolate;
  } lbSel_t;

endpackage

// File: rtl/lbk_ctrl.sv
module lbk_ctrl
  import lbk_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   localLbEn,
  input  logic   remoteLbEn,
  input  logic   speed100,
  output lbSel_t sel
);

  lbMode_e modeQ, modeD;
  logic    speedQ;

  // Local loopback has priority; remote is honoured only at 100 Mb/s.
  always_comb begin
    if (localLbEn)                   modeD = MODE_LOCAL;
    else if (remoteLbEn && speed100) modeD = MODE_REMOTE;
    else                             modeD = MODE_NORMAL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= MODE_NORMAL;
      speedQ <= 1'b1;
    end else begin
      modeQ  <= modeD;
      speedQ <= speed100;
    end
  end

  always_comb begin
    sel.loc100  = (modeQ == MODE_LOCAL) &&  speedQ;
    sel.loc10   = (modeQ == MODE_LOCAL) && !speedQ;
    sel.rem100  = (modeQ == MODE_REMOTE);
    sel.isolate = (modeQ == MODE_LOCAL);
  end

  // R8: local request one edge earlier wins over remote
  a_r8_local_priority: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(localLbEn)) |-> (sel.isolate && !sel.rem100));

  // R7: remote request at 10 Mb/s leaves the block in normal mode
  a_r7_no_remote_10m: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(localLbEn) && !$past(speed100)) |-> (sel == '0));

  // R9: steady controls give a steady selection
  a_r9_sel_steady: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $stable(localLbEn) && $stable(remoteLbEn) && $stable(speed100))
      |=> $stable(sel));

  // R3: at most one routing strobe active
  a_r3_one_route: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sel.loc100, sel.loc10, sel.rem100}));

endmodule

// File: rtl/lbk_datapath.sv
module lbk_datapath
  import lbk_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  lbSel_t       sel,
  input  logic [W-1:0] txNrziTap,
  input  logic [W-1:0] txManchTap,
  input  logic [W-1:0] rxRecovTap,
  input  logic [W-1:0] lineRx10,
  output logic [W-1:0] rxNrziDecIn,
  output logic [W-1:0] rxPllIn10,
  output logic [W-1:0] txMlt3In,
  output logic [W-1:0] tx10DrvIn,
  output logic         mediaIsolate
);

  localparam int LANES = W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign rxNrziDecIn[i] = sel.loc100 ? txNrziTap[i]  : rxRecovTap[i];
    assign rxPllIn10[i]   = sel.loc10  ? txManchTap[i] : lineRx10[i];
    assign txMlt3In[i]    = sel.rem100  ? rxRecovTap[i]
                          : sel.isolate ? 1'b0 : txNrziTap[i];
    assign tx10DrvIn[i]   = sel.isolate ? 1'b0 : txManchTap[i];
  end

  assign mediaIsolate = sel.isolate;

  // R3: isolated line drivers carry no data
  a_r3_quiet_line: assert property (@(posedge clk) disable iff (!rstN)
    mediaIsolate |-> (txMlt3In == '0 && tx10DrvIn == '0));

  // R4: 100 Mb/s local path wraps encoder output into decoder
  a_r4_local100_path: assert property (@(posedge clk) disable iff (!rstN)
    sel.loc100 |-> (rxNrziDecIn == txNrziTap && rxPllIn10 == lineRx10));

  // R5: 10 Mb/s local path wraps Manchester output into the PLL
  a_r5_local10_path: assert property (@(posedge clk) disable iff (!rstN)
    sel.loc10 |-> (rxPllIn10 == txManchTap && rxNrziDecIn == rxRecovTap));

  // R6: remote path returns recovered data to the line
  a_r6_remote_path: assert property (@(posedge clk) disable iff (!rstN)
    sel.rem100 |-> (txMlt3In == rxRecovTap && !mediaIsolate));

endmodule

// File: rtl/lbk_router.sv
module lbk_router
  import lbk_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         localLbEn,
  input  logic         remoteLbEn,
  input  logic         speed100,
  input  logic [W-1:0] txNrziTap,
  input  logic [W-1:0] txManchTap,
  input  logic [W-1:0] rxRecovTap,
  input  logic [W-1:0] lineRx10,
  output logic [W-1:0] rxNrziDecIn,
  output logic [W-1:0] rxPllIn10,
  output logic [W-1:0] txMlt3In,
  output logic [W-1:0] tx10DrvIn,
  output logic         mediaIsolate
);

  lbSel_t sel;

  lbk_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .localLbEn  (localLbEn),
    .remoteLbEn (remoteLbEn),
    .speed100   (speed100),
    .sel        (sel)
  );

  lbk_datapath #(.W(W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .sel          (sel),
    .txNrziTap    (txNrziTap),
    .txManchTap   (txManchTap),
    .rxRecovTap   (rxRecovTap),
    .lineRx10     (lineRx10),
    .rxNrziDecIn  (rxNrziDecIn),
    .rxPllIn10    (rxPllIn10),
    .txMlt3In     (txMlt3In),
    .tx10DrvIn    (tx10DrvIn),
    .mediaIsolate (mediaIsolate)
  );

endmodule

// File: tb/sim_lbk_router.sv
module sim_lbk_router;

  localparam int W = 4;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic localLbEn = 1'b0, remoteLbEn = 1'b0, speed100 = 1'b1;
  logic [W-1:0] txNrziTap = '0, txManchTap = '0, rxRecovTap = '0, lineRx10 = '0;
  logic [W-1:0] rxNrziDecIn, rxPllIn10, txMlt3In, tx10DrvIn;
  logic mediaIsolate;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbk_router #(.W(W)) u0 (
    .clk(clk), .rstN(rstN),
    .localLbEn(localLbEn), .remoteLbEn(remoteLbEn), .speed100(speed100),
    .txNrziTap(txNrziTap), .txManchTap(txManchTap),
    .rxRecovTap(rxRecovTap), .lineRx10(lineRx10),
    .rxNrziDecIn(rxNrziDecIn), .rxPllIn10(rxPllIn10),
    .txMlt3In(txMlt3In), .tx10DrvIn(tx10DrvIn),
    .mediaIsolate(mediaIsolate)
  );

  function automatic string tagOf(input logic l, input logic r, input logic s);
    if (l && r && s) return "R8";
    if (l && s)      return "R4";
    if (l)           return "R5";
    if (r && s)      return "R6";
    if (r)           return "R7";
    return "R2";
  endfunction

  task automatic checkMode(input logic l, input logic r, input logic s, input string tag);
    logic rem, loc;
    logic [W-1:0] eDec, ePll, eMlt, e10;
    loc  = l;
    rem  = !l && r && s;
    eDec = (loc && s)  ? txNrziTap  : rxRecovTap;
    ePll = (loc && !s) ? txManchTap : lineRx10;
    eMlt = rem ? rxRecovTap : (loc ? '0 : txNrziTap);
    e10  = loc ? '0 : txManchTap;
    checks++;
    if (rxNrziDecIn !== eDec || rxPllIn10 !== ePll || txMlt3In !== eMlt ||
        tx10DrvIn !== e10 || mediaIsolate !== loc) begin
      errors++;
      $display("FAIL %s mode l%0b r%0b s%0b: got dec=%h pll=%h mlt=%h t10=%h iso=%b exp dec=%h pll=%h mlt=%h t10=%h iso=%b",
               tag, l, r, s, rxNrziDecIn, rxPllIn10, txMlt3In, tx10DrvIn, mediaIsolate,
               eDec, ePll, eMlt, e10, loc);
    end
  endtask

  task automatic setData(input int k);
    logic [W-1:0] v;
    v = W'(k);
    txNrziTap  = v;
    txManchTap = v ^ W'(5);
    rxRecovTap = v ^ W'(10);
    lineRx10   = v ^ W'(15);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset holds normal routing even with loopback requested
    localLbEn = 1'b1; remoteLbEn = 1'b1; speed100 = 1'b1;
    setData(3);
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    checkMode(1'b0, 1'b0, 1'b1, "R1");
    localLbEn = 1'b0; remoteLbEn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    checkMode(1'b0, 1'b0, 1'b1, "R2");

    for (int p = 0; p < 8; p++) begin
      for (int n = 0; n < 8; n++) begin
        // establish previous mode
        @(negedge clk);
        localLbEn = p[2]; remoteLbEn = p[1]; speed100 = p[0];
        setData(p * 8 + n);
        @(posedge clk);
        // change controls and data at the falling edge
        @(negedge clk);
        localLbEn = n[2]; remoteLbEn = n[1]; speed100 = n[0];
        setData(p + n * 3 + 1);
        #1;
        // R9: before the edge, old routing with new data
        checkMode(p[2], p[1], p[0], "R9");
        @(posedge clk); #1;
        checkMode(n[2], n[1], n[0], tagOf(n[2], n[1], n[0]));
        if (n[2]) begin
          // R3: isolation in local loopback
          checks++;
          if (mediaIsolate !== 1'b1 || txMlt3In !== '0 || tx10DrvIn !== '0) begin
            errors++;
            $display("FAIL R3 iso=%b mlt=%h t10=%h exp iso=1 mlt=0 t10=0",
                     mediaIsolate, txMlt3In, tx10DrvIn);
          end
        end
        // R9: data-only change follows with no edge
        setData(p * 5 + n * 7 + 2);
        #1;
        checkMode(n[2], n[1], n[0], "R9");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule